// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit sits beside a small 8-bit processor core and decides when the core leaves its instruction stream for an exception handler. It collects requests from an external active-low interrupt pin, a port-change event, three timer status flags (capture, compare, overflow) and the software-interrupt instruction. At every instruction boundary it weighs them against the global interrupt mask and the per-source enables. When it enters an exception it asks the core's stacking logic to save the registers. Once stacking is done it emits a one-cycle take strobe together with the 16-bit vector address, and sets the global mask.

The mask bit is kept inside the unit. It is forced set by reset and by every exception entry, and a return-from-interrupt reloads it from the stacked value. The vector is chosen at vector-fetch time, not at the boundary. A request with a higher vector that arrives while the registers are being stacked therefore wins over the one that started the entry. All timer causes share the lowest vector. The port event shares the external-pin vector and its enable.

The unit is a five-state machine. HOLD is the reset state. RSTVEC issues the reset vector for one cycle. RUN waits for boundaries. STACK waits for the stacking handshake. VECTOR issues the exception vector for one cycle.

The transitions are:
- reset release moves HOLD to RSTVEC;
- RSTVEC always moves to RUN;
- a boundary with a takeable request moves RUN to STACK;
- the stacking acknowledge moves STACK to VECTOR;
- VECTOR always moves back to RUN.

Top module: `irq_arb`

## Requirements
- R1: While `rst_n` is low, `imask_o`=1 and `take_o`=0 and `stack_req_o`=0. In the first cycle after release, `take_o`=1 and `mask_set_o`=1 with `vec_o`=0x1FFE. That strobe lasts one cycle.
- R2: Requests are sampled only when `insn_done_i`=1. A pending request without a boundary starts nothing. After a boundary that enters an exception, `stack_req_o` is 1 in the next cycle.
- R3: A hardware request starts an entry only if the effective mask is 0 and the request's own enable is 1. Otherwise the boundary passes with no entry.
- R4: `swi_i`=1 at a boundary always starts an entry, whatever the mask.
- R5: With every take strobe, `mask_set_o`=1 and `imask_o` reads 1.
- R6: `rti_done_i`=1 in RUN loads `imask_o` from `stk_mask_i` on the next cycle and pulses `mask_restore_o` for that cycle. A boundary in the same cycle as `rti_done_i` is judged with `stk_mask_i` as the mask.
- R7: The vectors are fixed. Software interrupt is 0x1FFC. External pin and port event are 0x1FFA. Any timer source is 0x1FF8. Reset is 0x1FFE.
- R8: The vector is picked when `stack_done_i` is seen, with software above external above timer. A hardware request that became pending during stacking competes, provided the mask was open at the boundary.
- R9: A falling edge on `irq_pin_n`, after two synchronizer flops, sets an external latch. That latch stays set until the 0x1FFA vector is taken. A `port_evt_i` pulse is latched only while `port_opt_i`=1. The port event is gated by `irq_en_i` like the pin.
- R10: The timer request is the OR over i of `tmr_flag_i[i]` AND `tmr_en_i[i]`, where bit 0 is capture, bit 1 is compare and bit 2 is overflow. The unit never clears a flag, so a flag left set requests again once the mask opens.
- R11: `stack_req_o` holds until `stack_done_i`. `take_o` is 1 for exactly the one cycle after `stack_done_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| port_evt_i | input | 1 | One-cycle port-change event |
| port_opt_i | input | 1 | Option bit that connects the port event |
| irq_en_i | input | 1 | Enable for external pin and port event |
| tmr_flag_i | input | 3 | Timer status flags (capture, compare, overflow) |
| tmr_en_i | input | 3 | Per-flag timer enables |
| insn_done_i | input | 1 | Instruction boundary strobe |
| swi_i | input | 1 | Software-interrupt instruction completing (with boundary) |
| rti_done_i | input | 1 | Return-from-interrupt completing |
| stk_mask_i | input | 1 | Mask value recovered from the stack |
| stack_done_i | input | 1 | Register stacking finished |
| stack_req_o | output | 1 | Request to stack registers |
| take_o | output | 1 | Vector fetch strobe |
| vec_o | output | 16 | Vector address |
| mask_set_o | output | 1 | Mask being forced set |
| mask_restore_o | output | 1 | Mask reloaded from stack |
| imask_o | output | 1 | Current global interrupt mask |

## Verification
The bench targets requests that change during the stacking wait. If a unit picks its vector at the boundary, it returns the timer vector when an external edge arrives mid-stack. A timer flag left set across a return is also tested. If a unit cleared that request itself, it would never re-enter. The bench also checks a return and a boundary in the same cycle: judging that boundary with the old mask loses an entry. Finally, it checks a port event while the option is off, a software interrupt with the mask set, and a disabled external latch. A unit that leaked any of these would produce an extra vector, which the scoreboard does not expect.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Level doubles as priority: higher level, higher vector.
    typedef enum logic [1:0] {
        SRC_TMR = 2'd0,
        SRC_EXT = 2'd1,
        SRC_SWI = 2'd2,
        SRC_RST = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_RSTVEC = 3'd1,
        ST_RUN    = 3'd2,
        ST_STACK  = 3'd3,
        ST_VECTOR = 3'd4
    } state_e;

    function automatic logic [15:0] vec_of(input logic [15:0] base, input src_e s);
        return base + {13'd0, s, 1'b0};
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_n};
            prev_q <= sync_q[LAST];
        end
    end

    assign fall_o = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/irq_req_gather.sv
module irq_req_gather #(
    parameter int N_TMR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_fall,
    input  logic             port_evt,
    input  logic             port_opt,
    input  logic             ext_en,
    input  logic [N_TMR-1:0] tmr_flag,
    input  logic [N_TMR-1:0] tmr_en,
    input  logic             ext_clr,
    output logic             ext_req,
    output logic             tmr_req
);
    logic             ext_lat_q;
    logic             port_lat_q;
    logic [N_TMR-1:0] tmr_hit;

    // New edge wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_lat_q  <= 1'b0;
            port_lat_q <= 1'b0;
        end else begin
            ext_lat_q  <= ext_fall | (ext_lat_q & ~ext_clr);
            port_lat_q <= (port_evt & port_opt) | (port_lat_q & ~ext_clr);
        end
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        assign tmr_hit[g] = tmr_flag[g] & tmr_en[g];
    end

    assign tmr_req = |tmr_hit;
    assign ext_req = ext_en & (ext_lat_q | (port_opt & port_lat_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
(
    input  logic swi_req,
    input  logic ext_req,
    input  logic tmr_req,
    input  src_e fallback,
    output src_e pick,
    output logic any
);
    always_comb begin
        any = swi_req | ext_req | tmr_req;
        if (swi_req)      pick = SRC_SWI;
        else if (ext_req) pick = SRC_EXT;
        else if (tmr_req) pick = SRC_TMR;
        else              pick = fallback;
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_arb_pkg::*;
#(
    parameter logic [15:0] VEC_BASE    = 16'h1FF8,
    parameter int          N_TMR       = 3,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin_n,
    input  logic             port_evt_i,
    input  logic             port_opt_i,
    input  logic             irq_en_i,
    input  logic [N_TMR-1:0] tmr_flag_i,
    input  logic [N_TMR-1:0] tmr_en_i,
    input  logic             insn_done_i,
    input  logic             swi_i,
    input  logic             rti_done_i,
    input  logic             stk_mask_i,
    input  logic             stack_done_i,
    output logic             stack_req_o,
    output logic             take_o,
    output logic [15:0]      vec_o,
    output logic             mask_set_o,
    output logic             mask_restore_o,
    output logic             imask_o
);
    state_e      state_q, state_d;
    logic        swi_q, hw_ok_q, imask_q, restore_q;
    src_e        cause_q, pick;
    logic [15:0] vec_q;
    logic        ext_fall, ext_req, tmr_req, ext_clr;
    logic        eff_mask, hw_open, pick_any;
    logic        sel_swi, sel_ext, sel_tmr;
    logic        enter, fetch;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (irq_pin_n),
        .fall_o (ext_fall)
    );

    irq_req_gather #(.N_TMR(N_TMR)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_fall (ext_fall),
        .port_evt (port_evt_i),
        .port_opt (port_opt_i),
        .ext_en   (irq_en_i),
        .tmr_flag (tmr_flag_i),
        .tmr_en   (tmr_en_i),
        .ext_clr  (ext_clr),
        .ext_req  (ext_req),
        .tmr_req  (tmr_req)
    );

    // A return completing with this boundary already counts.
    assign eff_mask = rti_done_i ? stk_mask_i : imask_q;
    assign hw_open  = ~eff_mask;

    // At the boundary: live inputs. At fetch: latched SWI plus live hardware.
    always_comb begin
        if (state_q == ST_STACK) begin
            sel_swi = swi_q;
            sel_ext = hw_ok_q & ext_req;
            sel_tmr = hw_ok_q & tmr_req;
        end else begin
            sel_swi = swi_i;
            sel_ext = hw_open & ext_req;
            sel_tmr = hw_open & tmr_req;
        end
    end

    irq_prio_pick u_pick (
        .swi_req  (sel_swi),
        .ext_req  (sel_ext),
        .tmr_req  (sel_tmr),
        .fallback (cause_q),
        .pick     (pick),
        .any      (pick_any)
    );

    assign enter   = (state_q == ST_RUN) & insn_done_i & pick_any;
    assign fetch   = (state_q == ST_STACK) & stack_done_i;
    assign ext_clr = fetch & (pick == SRC_EXT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   state_d = ST_RSTVEC;
            ST_RSTVEC: state_d = ST_RUN;
            ST_RUN:    if (enter) state_d = ST_STACK;
            ST_STACK:  if (stack_done_i) state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_RUN;
            default:   state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swi_q     <= 1'b0;
            hw_ok_q   <= 1'b0;
            cause_q   <= SRC_TMR;
            vec_q     <= vec_of(VEC_BASE, SRC_RST);
            imask_q   <= 1'b1;
            restore_q <= 1'b0;
        end else begin
            restore_q <= (state_q == ST_RUN) & rti_done_i;
            if ((state_q == ST_RUN) && rti_done_i) imask_q <= stk_mask_i;
            if (enter) begin
                swi_q   <= swi_i;
                hw_ok_q <= hw_open;
                cause_q <= pick;
            end
            if (fetch) begin
                vec_q   <= vec_of(VEC_BASE, pick);
                imask_q <= 1'b1;
                swi_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        stack_req_o = 1'b0;
        take_o      = 1'b0;
        mask_set_o  = 1'b0;
        unique case (state_q)
            ST_HOLD:   ;
            ST_RUN:    ;
            ST_STACK:  stack_req_o = 1'b1;
            ST_RSTVEC,
            ST_VECTOR: begin
                take_o     = 1'b1;
                mask_set_o = 1'b1;
            end
            default:   ;
        endcase
        vec_o          = vec_q;
        mask_restore_o = restore_q;
        imask_o        = imask_q;
    end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter logic [15:0] VEC_BASE = 16'h1FF8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done_i,
    input logic        swi_i,
    input logic        rti_done_i,
    input logic        stk_mask_i,
    input logic        stack_done_i,
    input logic        stack_req_o,
    input logic        take_o,
    input logic [15:0] vec_o,
    input logic        mask_set_o,
    input logic        mask_restore_o,
    input logic        imask_o
);
    // R2: stacking only starts right after a boundary
    a_r2_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stack_req_o) |-> $past(insn_done_i));

    // R3: a hardware-only entry needs the effective mask open
    a_r3_mask_open: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stack_req_o) && !$past(swi_i)) |->
        ($past(rti_done_i) ? !$past(stk_mask_i) : !$past(imask_o)));

    // R5: mask is set whenever a vector is taken
    a_r5_mask_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o || mask_set_o) |-> imask_o);

    // R6: restored mask equals the stacked value
    a_r6_restore_value: assert property (@(posedge clk) disable iff (!rst_n)
        mask_restore_o |-> (imask_o == $past(stk_mask_i)));

    // R7: every vector lies in the table and is even
    a_r7_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_o[0] == 1'b0 && vec_o >= VEC_BASE && vec_o <= VEC_BASE + 16'd6));

    // R11: stacking request held until acknowledged
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_req_o && !stack_done_i) |=> stack_req_o);

    // R11: take strobe lasts one cycle
    a_r11_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

bind irq_arb irq_arb_chk #(.VEC_BASE(VEC_BASE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .insn_done_i    (insn_done_i),
    .swi_i          (swi_i),
    .rti_done_i     (rti_done_i),
    .stk_mask_i     (stk_mask_i),
    .stack_done_i   (stack_done_i),
    .stack_req_o    (stack_req_o),
    .take_o         (take_o),
    .vec_o          (vec_o),
    .mask_set_o     (mask_set_o),
    .mask_restore_o (mask_restore_o),
    .imask_o        (imask_o)
);

// File: tb/irq_arb_bench.sv
module irq_arb_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pin_n = 1'b1;
    logic        port_evt_i = 1'b0;
    logic        port_opt_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic [2:0]  tmr_flag_i = 3'b000;
    logic [2:0]  tmr_en_i = 3'b000;
    logic        insn_done_i = 1'b0;
    logic        swi_i = 1'b0;
    logic        rti_done_i = 1'b0;
    logic        stk_mask_i = 1'b0;
    logic        stack_done_i = 1'b0;
    logic        stack_req_o, take_o, mask_set_o, mask_restore_o, imask_o;
    logic [15:0] vec_o;

    int          n_checks = 0;
    int          n_fail = 0;
    int          n_takes = 0;
    int          stack_delay = 2;
    bit          finished = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    irq_arb u_irq_arb (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
        .port_evt_i(port_evt_i), .port_opt_i(port_opt_i), .irq_en_i(irq_en_i),
        .tmr_flag_i(tmr_flag_i), .tmr_en_i(tmr_en_i),
        .insn_done_i(insn_done_i), .swi_i(swi_i),
        .rti_done_i(rti_done_i), .stk_mask_i(stk_mask_i),
        .stack_done_i(stack_done_i), .stack_req_o(stack_req_o),
        .take_o(take_o), .vec_o(vec_o), .mask_set_o(mask_set_o),
        .mask_restore_o(mask_restore_o), .imask_o(imask_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic expect_vec(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: pop the scoreboard on every take strobe
    always @(negedge clk) begin
        if (rst_n && take_o) begin
            n_takes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected take", int'(vec_o), 0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(vec_o == e, t, int'(vec_o), int'(e));
                check(mask_set_o == 1'b1, "R5 mask_set with take", int'(mask_set_o), 1);
            end
        end
    end

    // Stacking responder
    initial begin
        forever begin
            @(negedge clk);
            if (stack_req_o && !stack_done_i) begin
                repeat (stack_delay - 1) @(negedge clk);
                stack_done_i = 1'b1;
                @(negedge clk);
                stack_done_i = 1'b0;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary(input bit swi);
        insn_done_i = 1'b1;
        swi_i = swi;
        @(negedge clk);
        insn_done_i = 1'b0;
        swi_i = 1'b0;
    endtask

    task automatic rti(input bit m, input bit with_boundary);
        rti_done_i = 1'b1;
        stk_mask_i = m;
        insn_done_i = with_boundary;
        @(negedge clk);
        rti_done_i = 1'b0;
        insn_done_i = 1'b0;
    endtask

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic irq_edge();
        irq_pin_n = 1'b0;
        idle(5);
        irq_pin_n = 1'b1;
        idle(3);
    endtask

    initial begin
        int t0;
        // R1: reset state
        idle(3);
        check(imask_o == 1'b1, "R1 imask in reset", imask_o, 1);
        check(take_o == 1'b0, "R1 no take in reset", take_o, 0);
        check(stack_req_o == 1'b0, "R1 no stack in reset", stack_req_o, 0);
        expect_vec(16'h1FFE, "R1 reset vector");
        rst_n = 1'b1;
        @(negedge clk);
        check(take_o == 1'b1, "R1 take after release", take_o, 1);
        idle(3);
        drained("R1 reset vector seen");
        check(imask_o == 1'b1, "R5 mask after reset vector", imask_o, 1);

        // R6: return reloads mask
        rti(1'b0, 1'b0);
        check(imask_o == 1'b0, "R6 mask restored", imask_o, 0);
        check(mask_restore_o == 1'b1, "R6 restore pulse", mask_restore_o, 1);

        // R3: flag set but disabled -> nothing
        t0 = n_takes;
        tmr_flag_i = 3'b100;
        boundary(1'b0);
        check(stack_req_o == 1'b0, "R3 disabled timer no stack", stack_req_o, 0);
        idle(10);
        check(n_takes == t0, "R3 disabled timer no take", n_takes, t0);

        // R10/R2: enabled overflow -> timer vector
        tmr_en_i = 3'b100;
        expect_vec(16'h1FF8, "R10 timer overflow vector");
        boundary(1'b0);
        check(stack_req_o == 1'b1, "R2 stack after boundary", stack_req_o, 1);
        idle(10);
        drained("R10 timer taken");
        check(imask_o == 1'b1, "R5 mask set after take", imask_o, 1);

        // R3: masked, flag still set -> nothing
        t0 = n_takes;
        boundary(1'b0);
        idle(10);
        check(n_takes == t0, "R3 masked timer no take", n_takes, t0);

        // R6/R10: return with boundary same cycle re-enters on uncleared flag
        expect_vec(16'h1FF8, "R10 re-request after return");
        rti(1'b0, 1'b1);
        idle(10);
        drained("R6 boundary with return");
        tmr_flag_i = 3'b000;

        // R4: software interrupt with mask set
        check(imask_o == 1'b1, "R4 precondition mask", imask_o, 1);
        expect_vec(16'h1FFC, "R4 swi under mask");
        boundary(1'b1);
        idle(10);
        drained("R4 swi taken");

        // R8/R9: external beats timer, latch clears, timer follows
        irq_en_i = 1'b1;
        tmr_en_i = 3'b001;
        tmr_flag_i = 3'b001;
        irq_edge();
        rti(1'b0, 1'b0);
        expect_vec(16'h1FFA, "R8 external over timer");
        boundary(1'b0);
        idle(10);
        drained("R8 external first");
        expect_vec(16'h1FF8, "R9 latch cleared then timer capture");
        rti(1'b0, 1'b1);
        idle(10);
        drained("R9 timer second");
        tmr_flag_i = 3'b000;
        t0 = n_takes;
        rti(1'b0, 1'b1);
        idle(10);
        check(n_takes == t0, "R9 latch empty after take", n_takes, t0);

        // R8: swi and external together
        irq_edge();
        expect_vec(16'h1FFC, "R8 swi over external");
        boundary(1'b1);
        idle(10);
        expect_vec(16'h1FFA, "R8 external after swi");
        rti(1'b0, 1'b1);
        idle(10);
        drained("R8 swi then external");

        // R2: pending external waits for a boundary
        rti(1'b0, 1'b0);
        t0 = n_takes;
        irq_edge();
        idle(10);
        check(n_takes == t0, "R2 no take without boundary", n_takes, t0);
        check(stack_req_o == 1'b0, "R2 no stack without boundary", stack_req_o, 0);
        expect_vec(16'h1FFA, "R2 taken at boundary");
        boundary(1'b0);
        idle(10);
        drained("R2 pending served");

        // R3: external disabled
        rti(1'b0, 1'b0);
        irq_en_i = 1'b0;
        irq_edge();
        t0 = n_takes;
        boundary(1'b0);
        idle(10);
        check(n_takes == t0, "R3 disabled external no take", n_takes, t0);
        irq_en_i = 1'b1;
        expect_vec(16'h1FFA, "R9 latch kept while disabled");
        boundary(1'b0);
        idle(10);
        drained("R9 held latch served");

        // R9: port event ignored with option off, taken with option on
        rti(1'b0, 1'b0);
        port_evt_i = 1'b1; @(negedge clk); port_evt_i = 1'b0;
        port_opt_i = 1'b1;
        t0 = n_takes;
        boundary(1'b0);
        idle(10);
        check(n_takes == t0, "R9 port event ignored without option", n_takes, t0);
        port_evt_i = 1'b1; @(negedge clk); port_evt_i = 1'b0;
        expect_vec(16'h1FFA, "R9 port event vector");
        boundary(1'b0);
        idle(10);
        drained("R9 port served");
        port_opt_i = 1'b0;

        // R8/R11: external arriving during slow stacking wins
        rti(1'b0, 1'b0);
        stack_delay = 10;
        tmr_en_i = 3'b010;
        tmr_flag_i = 3'b010;
        expect_vec(16'h1FFA, "R8 late external during stacking");
        boundary(1'b0);
        irq_pin_n = 1'b0;
        idle(4);
        check(stack_req_o == 1'b1, "R11 request held while stacking", stack_req_o, 1);
        irq_pin_n = 1'b1;
        idle(12);
        drained("R8 late external");
        stack_delay = 2;
        expect_vec(16'h1FF8, "R10 compare after external");
        rti(1'b0, 1'b1);
        idle(10);
        drained("R10 compare served");
        tmr_flag_i = 3'b000;
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "R11 watchdog expired", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule